// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break Generator

This block serialises bytes onto an asynchronous serial line and, on command, holds the line low as a break. A byte goes first into a one-entry holding register and moves to a frame shifter on the next bit-rate enable pulse. The shifter then emits a start bit, the data bits least significant first, an optional parity bit and one or more stop bits. Bit timing comes from an external one-cycle `bit_tick` enable. The block has no baud generator of its own.

A break is queued like a character. A start-break command waits until the shifter has finished its current frame. The line then goes low and stays low for at least one full frame time. After a stop-break command, the line returns high for a fixed recovery period before characters can flow again. Illegal or badly timed commands and data writes are dropped, so the line never reaches an undefined state.

Top module: `uart_brk_tx`

## Requirements
- R1: A frame is a 0 start bit, DATA_BITS data bits sent least significant first, a parity bit if PARITY_EN=1 (even parity when PARITY_ODD=0, odd parity otherwise), then STOP_BITS 1 bits. Each bit lasts one `bit_tick` period. A byte already waiting in the holding register starts on the same tick that ends the previous frame.
- R2: `tx_ready` is 1 when the holding register is empty and the break state allows data. A data write while `tx_ready`=1 is taken. A data write while `tx_ready`=0 is discarded.
- R3: On a control write, bit 9 of `ctrl_word` requests start-break and bit 10 requests stop-break. A write with both bits set is ignored completely.
- R4: Start-break is taken only when `tx_ready`=1 and no break is pending, active or recovering. Taking it drops `tx_ready` until the break starts. The frame in the shifter is finished before the line goes low.
- R5: The line stays low for at least CHAR_BITS tick periods (1+DATA_BITS+PARITY_EN+STOP_BITS). If stop-break was taken earlier, the low time is exactly CHAR_BITS periods. Otherwise it ends on the first tick after stop-break is taken.
- R6: After the low period, the line stays high for RECOV_BITS tick periods with `tx_ready`=0. After that, `tx_ready` returns to 1.
- R7: A stop-break command is ignored unless a break is low and no stop has been taken yet.
- R8: A data write while a break is pending, low or recovering is discarded. This holds even when `tx_ready`=1 during the low phase.
- R9: A start-break command during a low or recovering break is ignored.
- R10: `tx_empty` is 1 only when the shifter is idle, the holding register is empty and no break is low or recovering.
- R11: After reset, `txd`=1, `tx_ready`=1 and `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-rate enable |
| data_wr | input | 1 | Holding register write strobe |
| data_in | input | DATA_BITS | Byte to send |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_word | input | 16 | Control word; bit 9 start-break, bit 10 stop-break |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Nothing queued, sent or in break |

## Verification
Several properties are checked on every cycle:
- The line is high whenever the block reports empty.
- A pending break never loads the shifter and never shows ready.
- Recovery keeps the line high with ready low.
- A low period never ends before CHAR_BITS ticks, counted independently in the checker.
- Start commands during a break and dual-bit or stray stop commands never move the break state.

Only the bench scenarios, compared against a behavioural model on every clock, can show the rest:
- exact frame contents and parity;
- back-to-back framing;
- that discarded writes really vanish from the line;
- the exact low and recovery lengths for early and late stop commands.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    localparam int CMD_W     = 16;
    localparam int START_POS = 9;
    localparam int STOP_POS  = 10;

    typedef enum logic [1:0] {
        BRK_IDLE  = 2'd0,
        BRK_PEND  = 2'd1,
        BRK_LOW   = 2'd2,
        BRK_RECOV = 2'd3
    } brk_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } brk_cmd_t;

    // Both bits together form an illegal request and decode to nothing.
    function automatic brk_cmd_t decode_cmd(input logic wr, input logic [CMD_W-1:0] w);
        brk_cmd_t c;
        c.start = wr &  w[START_POS] & ~w[STOP_POS];
        c.stop  = wr & ~w[START_POS] &  w[STOP_POS];
        return c;
    endfunction

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          put_i,
    input  logic          take_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (put_i) begin
            valid_o <= 1'b1;
            data_o  <= data_i;
        end else if (take_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
    parameter int DW        = 8,
    parameter int PAR_EN    = 1,
    parameter int PAR_ODD   = 0,
    parameter int STOP_BITS = 1,
    parameter int CHAR_BITS = 1 + DW + PAR_EN + STOP_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          busy,
    output logic          last,
    output logic          bit_o
);
    localparam int CW = $clog2(CHAR_BITS + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(CHAR_BITS);

    logic [CHAR_BITS-1:0] frame;
    logic [CHAR_BITS-1:0] sreg;
    logic [CW-1:0]        cnt;

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) frame[1+i] = data[i];
        if (PAR_EN != 0) frame[1+DW] = (^data) ^ (PAR_ODD != 0);
    end

    assign busy  = (cnt != '0);
    assign last  = (cnt == CW'(1));
    assign bit_o = sreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
            cnt  <= '0;
        end else if (load) begin
            sreg <= frame;
            cnt  <= CNT_FULL;
        end else if (tick && busy) begin
            sreg <= {1'b1, sreg[CHAR_BITS-1:1]};
            cnt  <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
    import uart_brk_pkg::*;
#(
    parameter int CHAR_BITS  = 11,
    parameter int RECOV_BITS = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_acc,
    input  logic       stop_acc,
    input  logic       sh_free,
    output brk_state_e state,
    output logic       stop_req
);
    localparam int LW = $clog2(CHAR_BITS + 1);
    localparam int RW = $clog2(RECOV_BITS + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(CHAR_BITS - 1);
    localparam logic [RW-1:0] REC_LAST = RW'(RECOV_BITS - 1);

    logic [LW-1:0] low_cnt;
    logic [RW-1:0] rec_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BRK_IDLE;
            stop_req <= 1'b0;
            low_cnt  <= '0;
            rec_cnt  <= '0;
        end else begin
            case (state)
                BRK_IDLE: begin
                    if (start_acc) state <= BRK_PEND;
                end
                BRK_PEND: begin
                    if (tick && sh_free) begin
                        state   <= BRK_LOW;
                        low_cnt <= '0;
                    end
                end
                BRK_LOW: begin
                    if (tick && stop_req && low_cnt >= LOW_LAST) begin
                        state    <= BRK_RECOV;
                        rec_cnt  <= '0;
                        stop_req <= 1'b0;
                    end else begin
                        if (tick && low_cnt < LOW_LAST) low_cnt <= low_cnt + LW'(1);
                        if (stop_acc) stop_req <= 1'b1;
                    end
                end
                BRK_RECOV: begin
                    if (tick) begin
                        if (rec_cnt >= REC_LAST) state <= BRK_IDLE;
                        else rec_cnt <= rec_cnt + RW'(1);
                    end
                end
                default: state <= BRK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0,
    parameter int STOP_BITS  = 1,
    parameter int RECOV_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_tick,
    input  logic                 data_wr,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 ctrl_wr,
    input  logic [15:0]          ctrl_word,
    output logic                 txd,
    output logic                 tx_ready,
    output logic                 tx_empty
);
    localparam int CHAR_BITS = 1 + DATA_BITS + PARITY_EN + STOP_BITS;

    brk_state_e           brk_st;
    brk_cmd_t             cmd;
    logic                 stop_req;
    logic                 hold_v;
    logic [DATA_BITS-1:0] hold_data;
    logic                 sh_busy, sh_last, sh_bit, sh_free, sh_load;
    logic                 start_acc, stop_acc, data_acc;

    assign cmd       = decode_cmd(ctrl_wr, ctrl_word);
    assign sh_free   = !sh_busy || sh_last;
    assign tx_ready  = !hold_v && (brk_st == BRK_IDLE || (brk_st == BRK_LOW && !stop_req));
    assign start_acc = cmd.start && tx_ready && brk_st == BRK_IDLE;
    assign stop_acc  = cmd.stop && tx_ready && brk_st == BRK_LOW && !stop_req;
    assign data_acc  = data_wr && tx_ready && brk_st == BRK_IDLE && !start_acc;
    assign sh_load   = bit_tick && hold_v && brk_st == BRK_IDLE && sh_free;

    uart_brk_hold #(.DW(DATA_BITS)) u_hold (
        .clk(clk), .rst(rst), .put_i(data_acc), .take_i(sh_load),
        .data_i(data_in), .valid_o(hold_v), .data_o(hold_data)
    );

    uart_brk_shift #(
        .DW(DATA_BITS), .PAR_EN(PARITY_EN), .PAR_ODD(PARITY_ODD),
        .STOP_BITS(STOP_BITS), .CHAR_BITS(CHAR_BITS)
    ) u_shift (
        .clk(clk), .rst(rst), .tick(bit_tick), .load(sh_load), .data(hold_data),
        .busy(sh_busy), .last(sh_last), .bit_o(sh_bit)
    );

    uart_brk_ctrl #(.CHAR_BITS(CHAR_BITS), .RECOV_BITS(RECOV_BITS)) u_ctrl (
        .clk(clk), .rst(rst), .tick(bit_tick), .start_acc(start_acc),
        .stop_acc(stop_acc), .sh_free(sh_free), .state(brk_st), .stop_req(stop_req)
    );

    assign txd      = sh_busy ? sh_bit : (brk_st != BRK_LOW);
    assign tx_empty = !sh_busy && !hold_v && (brk_st == BRK_IDLE || brk_st == BRK_PEND);
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk
    import uart_brk_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CHAR_BITS = 11
) (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       ctrl_wr,
    input logic [15:0] ctrl_word,
    input logic       txd,
    input logic       tx_ready,
    input logic       tx_empty,
    input brk_state_e brk_st,
    input logic       stop_req,
    input logic       sh_busy,
    input logic       sh_load,
    input logic       hold_v,
    input logic [DW-1:0] hold_data
);
    int low_ticks;

    always_ff @(posedge clk) begin
        if (rst || brk_st != BRK_LOW) low_ticks <= 0;
        else if (bit_tick && low_ticks < CHAR_BITS) low_ticks <= low_ticks + 1;
    end

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd); // R10
    AST_PEND_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        brk_st == BRK_PEND |-> !tx_ready); // R4
    AST_PEND_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        brk_st == BRK_PEND |-> !sh_load); // R4
    AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (brk_st == BRK_LOW && !sh_busy) |-> !txd); // R5
    AST_LOW_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
        (brk_st == BRK_RECOV && $past(brk_st) == BRK_LOW) |-> $past(low_ticks) >= CHAR_BITS - 1); // R5
    AST_RECOV_HIGH: assert property (@(posedge clk) disable iff (rst)
        brk_st == BRK_RECOV |-> (txd && !tx_ready)); // R6
    AST_BOTH_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (brk_st == BRK_IDLE && ctrl_wr && ctrl_word[START_POS] && ctrl_word[STOP_POS]) |=> brk_st != BRK_PEND); // R3
    AST_STOP_IDLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (brk_st == BRK_IDLE && ctrl_wr && ctrl_word[STOP_POS]) |=> !stop_req); // R7
    AST_START_IN_BREAK: assert property (@(posedge clk) disable iff (rst)
        (brk_st == BRK_LOW || brk_st == BRK_RECOV) |=> brk_st != BRK_PEND); // R9
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (hold_v && !sh_load) |=> (hold_v && $stable(hold_data))); // R2
endmodule

bind uart_brk_tx uart_brk_tx_chk #(.DW(DATA_BITS), .CHAR_BITS(CHAR_BITS)) u_chk (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .brk_st(brk_st),
    .stop_req(stop_req), .sh_busy(sh_busy), .sh_load(sh_load),
    .hold_v(hold_v), .hold_data(hold_data)
);

// File: tb/uart_brk_tx_tb.sv
`timescale 1ns/1ps
module uart_brk_tx_tb;
    localparam int DW = 8, PEN = 1, PODD = 0, SB = 1, RECOV = 12;
    localparam int CHAR = 1 + DW + PEN + SB;

    logic clk = 0, rst = 1, bit_tick = 0, data_wr = 0, ctrl_wr = 0;
    logic [DW-1:0] data_in = '0;
    logic [15:0] ctrl_word = '0;
    logic txd, tx_ready, tx_empty;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R11";

    // model state
    bit  m_q[$];
    bit  m_hv, m_stop;
    logic [DW-1:0] m_hold;
    int  m_mode, m_low, m_rec;   // 0 idle, 1 pending, 2 low, 3 recovery

    always #10 clk = ~clk;

    uart_brk_tx #(.DATA_BITS(DW), .PARITY_EN(PEN), .PARITY_ODD(PODD),
                  .STOP_BITS(SB), .RECOV_BITS(RECOV)) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word), .txd(txd), .tx_ready(tx_ready),
        .tx_empty(tx_empty));

    function automatic bit m_ready();
        return !m_hv && (m_mode == 0 || (m_mode == 2 && !m_stop));
    endfunction

    always @(posedge clk) begin
        int sz;
        bit rdy, sc, pc, a_start, a_stop, a_data;
        if (rst) begin
            m_q.delete(); m_hv = 0; m_stop = 0; m_mode = 0; m_low = 0; m_rec = 0; m_hold = '0;
        end else begin
            sz  = m_q.size();
            rdy = m_ready();
            sc  = ctrl_wr && ctrl_word[9] && !ctrl_word[10];
            pc  = ctrl_wr && ctrl_word[10] && !ctrl_word[9];
            a_start = sc && rdy && m_mode == 0;
            a_stop  = pc && rdy && m_mode == 2 && !m_stop;
            a_data  = data_wr && rdy && m_mode == 0 && !a_start;
            if (bit_tick) begin
                if (m_mode == 0 && m_hv && sz <= 1) begin
                    m_q.delete();
                    m_q.push_back(1'b0);
                    for (int i = 0; i < DW; i++) m_q.push_back(m_hold[i]);
                    if (PEN != 0) m_q.push_back((^m_hold) ^ (PODD != 0));
                    for (int i = 0; i < SB; i++) m_q.push_back(1'b1);
                    m_hv = 0;
                end else if (sz > 0) begin
                    void'(m_q.pop_front());
                end
                case (m_mode)
                    1: if (sz <= 1) begin m_mode = 2; m_low = 0; end
                    2: if (m_stop && m_low + 1 >= CHAR) begin m_mode = 3; m_rec = 0; m_stop = 0; end
                       else m_low++;
                    3: if (m_rec + 1 >= RECOV) m_mode = 0; else m_rec++;
                    default: ;
                endcase
            end
            if (a_start) m_mode = 1;
            if (a_stop)  m_stop = 1;
            if (a_data) begin m_hv = 1; m_hold = data_in; end
        end
    end

    task automatic check1(string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", cur_req, what, cyc, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        bit_tick <= (cyc % 4 == 0);
        if (!rst && !done) begin
            check1("txd", txd, (m_q.size() > 0) ? m_q[0] : (m_mode != 2));
            check1("tx_ready", tx_ready, m_ready());
            check1("tx_empty", tx_empty, m_q.size() == 0 && !m_hv && m_mode <= 1);
        end
    end

    task automatic wait_ready();
        while (!tx_ready) @(negedge clk);
    endtask
    task automatic wait_empty();
        while (!tx_empty) @(negedge clk);
    endtask
    task automatic put_byte(logic [DW-1:0] b);
        data_in = b; data_wr = 1; @(negedge clk); data_wr = 0;
    endtask
    task automatic put_cmd(logic [15:0] w);
        ctrl_word = w; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0; ctrl_word = '0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3); rst = 0;
        @(negedge clk);
        cur_req = "R11";
        check1("reset txd", txd, 1'b1);
        check1("reset ready", tx_ready, 1'b1);
        check1("reset empty", tx_empty, 1'b1);

        // R1 framing, back-to-back, parity
        cur_req = "R1";
        wait_ready(); put_byte(8'hA5);
        wait_ready(); put_byte(8'h3C);
        wait_ready(); put_byte(8'hFF);
        // R2 write into full holding register is dropped
        cur_req = "R2";
        put_byte(8'h00); put_byte(8'h81);
        wait_ready(); put_byte(8'h01);
        cur_req = "R10";
        wait_empty(); idle(6);

        // R4 start-break while a frame is shifting, R5 exact length with early stop
        cur_req = "R4";
        wait_ready(); put_byte(8'h5A);
        wait_ready(); idle(2); put_cmd(16'h0200);
        cur_req = "R5";
        wait_ready(); put_cmd(16'h0400);
        cur_req = "R6";
        wait_ready(); put_byte(8'hC3);
        wait_empty(); idle(5);

        // R8 data during pending and low break, R9 start during break, late stop
        cur_req = "R8";
        wait_ready(); put_byte(8'h77);
        wait_ready(); put_cmd(16'h0200);
        put_byte(8'h11);
        wait_ready(); put_byte(8'h22);
        cur_req = "R9";
        idle(10); put_cmd(16'h0200);
        cur_req = "R5";
        idle(70); put_cmd(16'h0400);
        cur_req = "R9";
        idle(8); put_cmd(16'h0200);
        cur_req = "R7";
        put_cmd(16'h0400);
        cur_req = "R6";
        wait_empty(); idle(8);

        // R7 stray stop, R3 both bits together
        cur_req = "R7";
        put_cmd(16'h0400); idle(12);
        cur_req = "R3";
        put_cmd(16'h0600); idle(12);
        check1("both-bit write kept ready", tx_ready, 1'b1);
        check1("both-bit write kept line high", txd, 1'b1);
        wait_ready(); put_byte(8'h96);
        cur_req = "R10";
        wait_empty(); idle(8);
        finish_run();
    end
endmodule